// File: doc/BRIEF.md
# Nibble-Serial Program ROM Port

This block sits on the memory side of a narrow processor bus that carries both addresses and instruction bytes over four shared wires. Every instruction cycle is a fixed frame of eight clocks. The processor places a 12-bit program address on the bus as three 4-bit pieces, one per clock. The block assembles these pieces, looks up the byte held at that address in its internal 4096 x 8 read-only array, and returns the byte as two 4-bit pieces in the two clocks that follow. For the remaining three clocks of the frame the block stays off the bus.

Frames are aligned by a sync input that the processor pulses for one clock just before the first address clock. A 3-bit phase counter restarts on every sync and otherwise wraps from 7 back to 0, so frames continue back to back without further syncs. The array contents come from a parameter evaluated at elaboration. The shared bus is presented as a separate input, output and output-enable so that the pad-level tristate stays outside the block.

Top module: `nibble_rom_port`

## Requirements
- R1: After reset, and until the first sync is seen, `bus_oe` is 0 and `bus_out` is 0 whatever appears on `bus_in`.
- R2: A sync sampled high at a clock edge makes the following clock phase 0 of a new frame, at any point of the current frame; no nibble of the interrupted frame is driven after that edge.
- R3: Without a sync the phase advances by one per clock and wraps from 7 to 0, so a new frame starts every eight clocks.
- R4: In phases 0, 1 and 2 the bus input is taken as address bits [3:0], [7:4] and [11:8] in that order; the bus input in phases 3 to 7 has no effect on any later output.
- R5: In phase 3 the block drives bits [7:4] of the byte stored at the assembled address, with `bus_oe` = 1.
- R6: In phase 4 the block drives bits [3:0] of that same byte, with `bus_oe` = 1.
- R7: In phases 0, 1, 2, 5, 6 and 7 `bus_oe` is 0, and whenever `bus_oe` is 0 `bus_out` is 0.
- R8: With the default image, the byte at address a is (29·a XOR 7·floor(a/16) XOR 0xA5) mod 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Frame alignment pulse, high in the clock before phase 0 |
| bus_in | input | 4 | Value seen on the shared bus |
| bus_out | output | 4 | Value the block places on the shared bus |
| bus_oe | output | 1 | High when the block owns the shared bus |

## Verification
The bench keeps its own phase, address and byte model and compares both bus outputs on every clock, feeding random noise on the bus in every phase that should be ignored, so a design that latched a nibble in the wrong phase or let a data-phase input leak into the address would return the wrong byte in a later frame. Addresses 0x000 and 0xFFF and random ones are used, which catches nibble order swaps and a truncated top nibble. Syncs arrive mid-frame (in the last address clock and in the first data clock) and back to back, where a design that did not restart at once would still drive a stale nibble. Long runs without sync check the wrap from 7 to 0, and the interval before the first sync checks that nothing is driven from an unaligned counter.

// File: rtl/nrom_pkg.sv
package nrom_pkg;

    localparam int DEF_NIB_W      = 4;
    localparam int DEF_ADDR_NIBS  = 3;
    localparam int DEF_DATA_NIBS  = 2;
    localparam int DEF_ADDR_W     = DEF_NIB_W * DEF_ADDR_NIBS;
    localparam int DEF_DATA_W     = DEF_NIB_W * DEF_DATA_NIBS;
    localparam int DEF_WORDS      = 1 << DEF_ADDR_W;
    localparam int DEF_IMAGE_BITS = DEF_WORDS * DEF_DATA_W;
    localparam int ROW_LEN        = 64;

    // Filler pattern for the default array contents
    function automatic logic [DEF_DATA_W-1:0] pattern_byte(input int addr);
        int v;
        v = (addr * 29) ^ ((addr >> 4) * 7) ^ 32'hA5;
        return v[DEF_DATA_W-1:0];
    endfunction

    // Two nested loops keep each loop short for elaboration-time evaluation
    function automatic logic [DEF_IMAGE_BITS-1:0] default_image();
        logic [DEF_IMAGE_BITS-1:0] img;
        img = '0;
        for (int row = 0; row < DEF_WORDS / ROW_LEN; row++) begin
            for (int col = 0; col < ROW_LEN; col++) begin
                img[(row*ROW_LEN + col)*DEF_DATA_W +: DEF_DATA_W] = pattern_byte(row*ROW_LEN + col);
            end
        end
        return img;
    endfunction

endpackage

// File: rtl/nrom_phase_seq.sv
module nrom_phase_seq #(
    parameter int FRAME_LEN = 8,
    parameter int PH_W      = $clog2(FRAME_LEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sync_i,
    output logic [PH_W-1:0] phase_o,
    output logic            framed_o
);

    localparam logic [PH_W-1:0] LAST_PH = PH_W'(FRAME_LEN - 1);

    typedef struct packed {
        logic [PH_W-1:0] phase;
        logic            framed;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (sync_i) begin
            seq_d.phase  = '0;
            seq_d.framed = 1'b1;
        end else if (seq_q.phase == LAST_PH) begin
            seq_d.phase = '0;
        end else begin
            seq_d.phase = seq_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{phase: LAST_PH, framed: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign phase_o  = seq_q.phase;
    assign framed_o = seq_q.framed;

    // R2: a sync always opens a frame at phase 0
    a_r2_sync_restart: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> (phase_o == '0) && framed_o);

    // R3: the last phase rolls over to 0 on its own
    a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_i && phase_o == LAST_PH) |=> (phase_o == '0));

endmodule

// File: rtl/nrom_addr_collect.sv
module nrom_addr_collect #(
    parameter int NIB_W     = 4,
    parameter int ADDR_NIBS = 3,
    parameter int PH_W      = 3,
    parameter int ADDR_W    = NIB_W * ADDR_NIBS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              framed_i,
    input  logic [PH_W-1:0]   phase_i,
    input  logic [NIB_W-1:0]  bus_in,
    output logic [ADDR_W-1:0] addr_o,
    output logic [ADDR_W-1:0] addr_next_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } col_t;

    col_t col_d, col_q;

    always_comb begin
        col_d = col_q;
        for (int k = 0; k < ADDR_NIBS; k++) begin
            if (framed_i && phase_i == PH_W'(k)) begin
                col_d.addr[k*NIB_W +: NIB_W] = bus_in;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q <= '0;
        end else begin
            col_q <= col_d;
        end
    end

    assign addr_o = col_q.addr;

    // Full address as seen during the last address clock: the newest nibble
    // comes straight from the bus, the older ones from the register
    generate
        for (genvar g = 0; g < ADDR_NIBS; g++) begin : g_slot
            if (g == ADDR_NIBS - 1) begin : g_live
                assign addr_next_o[g*NIB_W +: NIB_W] = bus_in;
            end else begin : g_held
                assign addr_next_o[g*NIB_W +: NIB_W] = col_q.addr[g*NIB_W +: NIB_W];
            end

            // R4: each address clock stores its nibble in its own slice
            a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
                (framed_i && phase_i == PH_W'(g)) |=>
                    (addr_o[g*NIB_W +: NIB_W] == $past(bus_in)));
        end
    endgenerate

    // R4: bus input outside the address clocks leaves the address alone
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i >= PH_W'(ADDR_NIBS)) |=> $stable(addr_o));

endmodule

// File: rtl/nrom_rom_lookup.sv
module nrom_rom_lookup #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8,
    parameter int WORDS  = 1 << ADDR_W,
    parameter logic [WORDS*DATA_W-1:0] IMAGE = '0
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [DATA_W-1:0] word_o
);

    always_comb begin
        word_o = IMAGE[int'(addr_i)*DATA_W +: DATA_W];
    end

endmodule

// File: rtl/nibble_rom_port.sv
module nibble_rom_port #(
    parameter int NIB_W     = 4,
    parameter int ADDR_NIBS = 3,
    parameter int DATA_NIBS = 2,
    parameter int FRAME_LEN = 8,
    parameter logic [((NIB_W*DATA_NIBS) << (NIB_W*ADDR_NIBS))-1:0] ROM_IMAGE =
        nrom_pkg::default_image()
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_i,
    input  logic [NIB_W-1:0] bus_in,
    output logic [NIB_W-1:0] bus_out,
    output logic             bus_oe
);

    localparam int ADDR_W  = NIB_W * ADDR_NIBS;
    localparam int DATA_W  = NIB_W * DATA_NIBS;
    localparam int WORDS   = 1 << ADDR_W;
    localparam int PH_W    = $clog2(FRAME_LEN);
    localparam logic [PH_W-1:0] LOAD_PH  = PH_W'(ADDR_NIBS - 1);
    localparam logic [PH_W-1:0] FIRST_DR = PH_W'(ADDR_NIBS);
    localparam logic [PH_W-1:0] LAST_DR  = PH_W'(ADDR_NIBS + DATA_NIBS - 1);

    logic [PH_W-1:0]   phase;
    logic              framed;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_next;
    logic [DATA_W-1:0] rom_word;

    nrom_phase_seq #(
        .FRAME_LEN (FRAME_LEN),
        .PH_W      (PH_W)
    ) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_i   (sync_i),
        .phase_o  (phase),
        .framed_o (framed)
    );

    nrom_addr_collect #(
        .NIB_W     (NIB_W),
        .ADDR_NIBS (ADDR_NIBS),
        .PH_W      (PH_W),
        .ADDR_W    (ADDR_W)
    ) i_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .framed_i    (framed),
        .phase_i     (phase),
        .bus_in      (bus_in),
        .addr_o      (addr_q),
        .addr_next_o (addr_next)
    );

    nrom_rom_lookup #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .WORDS  (WORDS),
        .IMAGE  (ROM_IMAGE)
    ) i_rom (
        .addr_i (addr_next),
        .word_o (rom_word)
    );

    typedef struct packed {
        logic              oe;
        logic [NIB_W-1:0]  nib;
        logic [DATA_W-1:0] word;
    } drv_t;

    drv_t drv_d, drv_q;

    // Output is registered: the decision taken in clock p shows in clock p+1
    always_comb begin
        drv_d      = drv_q;
        drv_d.oe   = 1'b0;
        drv_d.nib  = '0;
        if (framed && !sync_i) begin
            if (phase == LOAD_PH) begin
                drv_d.word = rom_word;
                drv_d.oe   = 1'b1;
                drv_d.nib  = rom_word[DATA_W-1 -: NIB_W];
            end else if (phase >= FIRST_DR && phase < LAST_DR) begin
                drv_d.word = drv_q.word << NIB_W;
                drv_d.oe   = 1'b1;
                drv_d.nib  = drv_d.word[DATA_W-1 -: NIB_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_q <= '0;
        end else begin
            drv_q <= drv_d;
        end
    end

    assign bus_out = drv_q.nib;
    assign bus_oe  = drv_q.oe;

    // R1: nothing is driven before the first sync
    a_r1_no_drive_unframed: assert property (@(posedge clk) disable iff (!rst_n)
        !framed |-> !bus_oe);

    // R7: bus ownership only inside the data window
    a_r7_oe_window: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (phase >= FIRST_DR && phase <= LAST_DR));

    // R7: an idle output is all zero
    a_r7_quiet_low: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_out == '0));

    // R6: the first data clock is always followed by the second one
    a_r6_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && phase == FIRST_DR && !sync_i) |=> bus_oe);

endmodule

// File: tb/test_nibble_rom_port.sv
`timescale 1ns/1ps
module test_nibble_rom_port;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sync_i;
    logic [3:0] bus_in;
    logic [3:0] bus_out;
    logic       bus_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string ctx = "R1";
    logic [31:0] seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    nibble_rom_port i_nibble_rom_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_i  (sync_i),
        .bus_in  (bus_in),
        .bus_out (bus_out),
        .bus_oe  (bus_oe)
    );

    // Reference model (R8 formula, independent of the design)
    function automatic int rom_byte(input int a);
        return ((a * 29) ^ ((a / 16) * 7) ^ 'hA5) & 'hFF;
    endfunction

    int m_ph, m_addr, m_word, exp_nib;
    bit m_fr, exp_oe;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 7; m_fr = 0; m_addr = 0; m_word = 0; exp_oe = 0; exp_nib = 0;
        end else begin
            bit n_oe;
            int n_nib;
            int b;
            b = int'(bus_in);
            n_oe = 0; n_nib = 0;
            if (m_fr && !sync_i) begin
                if (m_ph == 2) begin
                    m_word = rom_byte((m_addr & 'hFF) | (b << 8));
                    n_oe = 1; n_nib = m_word >> 4;
                end else if (m_ph == 3) begin
                    n_oe = 1; n_nib = m_word & 'hF;
                end
            end
            if (m_fr && m_ph < 3)
                m_addr = (m_addr & ~('hF << (4*m_ph))) | (b << (4*m_ph));
            if (sync_i) begin m_ph = 0; m_fr = 1; end
            else m_ph = (m_ph + 1) % 8;
            exp_oe = n_oe; exp_nib = n_nib;
        end
    end

    function automatic logic [3:0] rnd4();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed[19:16];
    endfunction

    task automatic compare();
        string ptag;
        if (!m_fr)            ptag = "R1";
        else if (m_ph == 3)   ptag = "R5/R8";
        else if (m_ph == 4)   ptag = "R6/R8";
        else                  ptag = "R7";
        checks++;
        if (bus_oe !== exp_oe || bus_out !== 4'(exp_nib)) begin
            fails++;
            $display("FAIL %s %s phase %0d: oe=%0b out=%h expected oe=%0b out=%h",
                     ctx, ptag, m_ph, bus_oe, bus_out, exp_oe, 4'(exp_nib));
        end
    endtask

    task automatic step(input bit s, input logic [3:0] nib);
        @(negedge clk);
        compare();
        sync_i = s;
        bus_in = nib;
    endtask

    // One 8-clock frame; noise on the bus outside the address clocks (R4)
    task automatic run_frame(input logic [11:0] a, input bit resync);
        for (int p = 0; p < 8; p++) begin
            logic [3:0] nib;
            nib = (p < 3) ? a[4*p +: 4] : rnd4();
            step(resync && (p == 7), nib);
        end
    endtask

    initial begin
        rst_n = 1'b0; sync_i = 1'b0; bus_in = 4'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (bus_oe !== 1'b0 || bus_out !== 4'h0) begin
            fails++;
            $display("FAIL R1 reset: oe=%0b out=%h expected oe=0 out=0", bus_oe, bus_out);
        end

        ctx = "R1 before sync";
        for (int i = 0; i < 12; i++) step(0, rnd4());

        ctx = "R2 first sync";
        step(1, rnd4());
        ctx = "R4 addr 000";  run_frame(12'h000, 1);
        ctx = "R4 addr FFF";  run_frame(12'hFFF, 1);
        ctx = "R8 addr 5A3";  run_frame(12'h5A3, 1);
        ctx = "R3 wrap";      run_frame(12'h123, 0);
        run_frame(12'h456, 0);
        run_frame(12'h789, 1);

        ctx = "R2 sync in clock 2";
        step(0, 4'hA); step(0, 4'hB); step(1, 4'hC);
        run_frame(12'hABC, 1);

        ctx = "R2 sync in clock 3";
        step(0, 4'h1); step(0, 4'hE); step(0, 4'h7); step(1, rnd4());
        run_frame(12'h0F0, 1);

        ctx = "R2 back to back sync";
        step(1, rnd4()); step(1, rnd4());
        run_frame(12'h801, 1);

        ctx = "R4 random";
        for (int f = 0; f < 400; f++) begin
            logic [11:0] a;
            a = {rnd4(), rnd4(), rnd4()};
            run_frame(a, rnd4() > 4'h5);
        end

        ctx = "R7 tail";
        for (int i = 0; i < 10; i++) step(0, rnd4());

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule